// File: doc/BRIEF.md
# Timer Count Latch and Read-Back Unit

This block is the host read path for a bank of three programmable interval timer channels. It sees every byte written to the timer control port and decodes two kinds of command from it. A single-channel count-freeze command and a multi-channel read-back command both take snapshots of the live count or the status of a channel. A write that programs a channel's operating mode resets that channel's read state. The channel counters themselves sit outside this block. Each one presents its live count, operating mode, BCD flag, byte-access mode, output level and a "count not yet loaded" flag.

A host read of a channel's data port returns one byte on `rd_data`, in the cycle after the read strobe. A pending status snapshot always goes out first. A frozen count goes out next, and the live count is used when nothing is frozen. The byte order follows the channel's access mode. In low-then-high mode, a per-channel pointer alternates between the low byte and the high byte. In BCD mode, the count is returned as four decimal digits.

Top module: `timer_readback`

## Requirements
- R1: A control write with select bits [7:6] equal to 0, 1 or 2 and access bits [5:4] equal to 00 freezes that channel's current count. Later count reads return the frozen value even if the live count moves.
- R2: A freeze request for a channel that still holds an unreleased frozen count has no effect. The old snapshot stays.
- R3: A control write with bits [7:6] = 11 and bit 5 = 0 freezes the count of every channel whose enable bit is set. Bit 1 enables channel 0, bit 2 enables channel 1 and bit 3 enables channel 2.
- R4: In a select-11 write with bit 4 = 0, a status snapshot is taken only for the lowest-numbered enabled channel.
- R5: The status byte holds the output level in bit 7, the not-loaded flag in bit 6, the access mode in bits 5:4, the operating mode in bits 3:1 and the BCD flag in bit 0.
- R6: A pending status snapshot is not replaced by later status requests. It stays until it is read or a mode word arrives for that channel.
- R7: The first read after a status snapshot returns the status byte and clears it. The byte pointer does not move, and later reads return count bytes.
- R8: Access mode 11 returns the low byte and then the high byte. A frozen count is released only after the high byte has been read.
- R9: Access mode 01 returns only the low byte and mode 10 returns only the high byte. Each read releases a frozen count.
- R10: With the BCD flag set, the count, whether frozen or live, is returned as four packed BCD digits of the binary value modulo 10000.
- R11: With no frozen count, a read returns bytes of the live count in the same order as R8 and R9.
- R12: A mode word (select 0 to 2, access bits not 00) for a channel clears its frozen count, its pending status and its byte pointer.
- R13: `rd_data` is registered, changes only in the cycle after a read strobe, and is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control port write strobe |
| ctl_data | input | 8 | Control byte |
| rd_en | input | 1 | Data port read strobe |
| rd_sel | input | 2 | Channel being read (0 to 2) |
| live_cnt | input | 3*CW | Live counts, channel 0 in the low bits |
| ch_mode | input | 9 | Operating mode per channel, 3 bits each |
| ch_bcd | input | 3 | BCD flag per channel |
| ch_acc | input | 6 | Access mode per channel, 2 bits each |
| ch_out | input | 3 | Output level per channel |
| ch_null | input | 3 | Count-not-loaded flag per channel |
| rd_data | output | 8 | Registered read byte |

## Verification
The properties assume that a control write and a data read never fall in the same cycle, that `rd_sel` is never 3 while `rd_en` is high, and that a channel's access mode changes only together with a mode word for that channel. The stimulus keeps to these rules by issuing exactly one host operation per cycle. It changes a channel's access input only in the cycle of the mode word that reprograms it. It changes live counts and flags freely between operations, which exercises freezing and release.

// File: rtl/timer_rb_pkg.sv
package timer_rb_pkg;
  localparam int NCH = 3;  // fixed by the three enable bits of the read-back command

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  // R5: status byte packing
  function automatic logic [7:0] pack_status(input logic out_l, input logic nul,
                                             input logic [1:0] acc, input logic [2:0] mode,
                                             input logic bcd);
    return {out_l, nul, acc, mode, bcd};
  endfunction
endpackage

// File: rtl/trb_bcd_conv.sv
// Shift-and-add-3 conversion; keeps CW/4 decimal digits (value modulo 10^(CW/4)).
module trb_bcd_conv #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] bin,
  output logic [CW-1:0] dec
);
  localparam int NDIG = CW / 4;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = CW - 1; i >= 0; i--) begin
      for (int d = 0; d < NDIG; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[CW-2:0], bin[i]};
    end
    dec = acc;
  end
endmodule

// File: rtl/trb_cmd_dec.sv
module trb_cmd_dec
  import timer_rb_pkg::*;
(
  input  logic           we,
  input  logic [7:0]     wd,
  output logic [NCH-1:0] lat_cnt,
  output logic [NCH-1:0] lat_sts,
  output logic [NCH-1:0] new_mode
);
  logic rb;
  logic unused_bcd_bit;
  assign unused_bcd_bit = wd[0];
  assign rb = (wd[7:6] == 2'b11);

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      // R1 / R3: count freeze, single or multi-channel
      lat_cnt[c]  = we && (rb ? (!wd[5] && wd[c+1])
                              : (wd[7:6] == 2'(c) && wd[5:4] == ACC_NONE));
      // R4: status only for lowest enabled channel
      lat_sts[c]  = we && rb && !wd[4] && wd[c+1] && !seen;
      seen        = seen | wd[c+1];
      // R12: mode word
      new_mode[c] = we && !rb && wd[7:6] == 2'(c) && wd[5:4] != ACC_NONE;
    end
  end
endmodule

// File: rtl/trb_chan.sv
module trb_chan
  import timer_rb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] live,
  input  logic [2:0]    mode_f,
  input  logic          bcd_f,
  input  logic [1:0]    acc_f,
  input  logic          out_f,
  input  logic          null_f,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic          new_mode,
  input  logic          rd_hit,
  output logic [7:0]    rd_byte,
  output logic          cnt_held,
  output logic          sts_held,
  output logic          hi_next,
  output logic [CW-1:0] cnt_q,
  output logic [7:0]    sts_q
);
  logic [CW-1:0] live_dec, live_fmt, src;

  trb_bcd_conv #(.CW(CW)) u_bcd (.bin(live), .dec(live_dec));

  assign live_fmt = bcd_f ? live_dec : live;          // R10
  assign src      = cnt_held ? cnt_q : live_fmt;      // R1 / R11

  always_comb begin
    if (sts_held) rd_byte = sts_q;                    // R7
    else begin
      case (acc_e'(acc_f))
        ACC_LO:  rd_byte = src[7:0];
        ACC_HI:  rd_byte = src[15:8];
        default: rd_byte = hi_next ? src[15:8] : src[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      hi_next  <= 1'b0;
      cnt_q    <= '0;
      sts_q    <= '0;
    end else begin
      if (rd_hit) begin
        if (sts_held) sts_held <= 1'b0;
        else begin
          case (acc_e'(acc_f))
            ACC_LO, ACC_HI: cnt_held <= 1'b0;          // R9
            default: begin                             // R8
              hi_next <= !hi_next;
              if (hi_next) cnt_held <= 1'b0;
            end
          endcase
        end
      end
      if (lat_cnt && !cnt_held) begin                  // R2
        cnt_held <= 1'b1;
        cnt_q    <= live_fmt;
      end
      if (lat_sts && !sts_held) begin                  // R6
        sts_held <= 1'b1;
        sts_q    <= pack_status(out_f, null_f, acc_f, mode_f, bcd_f);
      end
      if (new_mode) begin                              // R12
        cnt_held <= 1'b0;
        sts_held <= 1'b0;
        hi_next  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/timer_readback.sv
module timer_readback
  import timer_rb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic [NCH*CW-1:0] live_cnt,
  input  logic [NCH*3-1:0]  ch_mode,
  input  logic [NCH-1:0]    ch_bcd,
  input  logic [NCH*2-1:0]  ch_acc,
  input  logic [NCH-1:0]    ch_out,
  input  logic [NCH-1:0]    ch_null,
  output logic [7:0]        rd_data
);
  logic [NCH-1:0]    lat_cnt, lat_sts, new_mode, rd_hit;
  logic [NCH-1:0]    cnt_held_v, sts_held_v, hi_next_v;
  logic [NCH*CW-1:0] cnt_q_v;
  logic [NCH*8-1:0]  sts_q_v;
  logic [7:0]        byte_v [NCH];

  trb_cmd_dec u_dec (
    .we(ctl_we), .wd(ctl_data),
    .lat_cnt(lat_cnt), .lat_sts(lat_sts), .new_mode(new_mode)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rd_hit[c] = rd_en && (rd_sel == 2'(c));
    trb_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst),
      .live(live_cnt[c*CW +: CW]),
      .mode_f(ch_mode[c*3 +: 3]),
      .bcd_f(ch_bcd[c]),
      .acc_f(ch_acc[c*2 +: 2]),
      .out_f(ch_out[c]),
      .null_f(ch_null[c]),
      .lat_cnt(lat_cnt[c]),
      .lat_sts(lat_sts[c]),
      .new_mode(new_mode[c]),
      .rd_hit(rd_hit[c]),
      .rd_byte(byte_v[c]),
      .cnt_held(cnt_held_v[c]),
      .sts_held(sts_held_v[c]),
      .hi_next(hi_next_v[c]),
      .cnt_q(cnt_q_v[c*CW +: CW]),
      .sts_q(sts_q_v[c*8 +: 8])
    );
  end

  // R13: registered read byte
  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_en && int'(rd_sel) < NCH) rd_data <= byte_v[rd_sel];
  end
endmodule

// File: rtl/trb_chk.sv
module trb_chk
  import timer_rb_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [7:0]        ctl_data,
  input logic              rd_en,
  input logic [1:0]        rd_sel,
  input logic [7:0]        rd_data,
  input logic [NCH-1:0]    cnt_held_v,
  input logic [NCH-1:0]    sts_held_v,
  input logic [NCH-1:0]    hi_next_v,
  input logic [NCH*CW-1:0] cnt_q_v,
  input logic [NCH*8-1:0]  sts_q_v
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sts_held_v & ~$past(sts_held_v))); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R13

  for (genvar c = 0; c < NCH; c++) begin : g_a
    logic mw, rh;
    assign mw = ctl_we && ctl_data[7:6] == 2'(c) && ctl_data[5:4] != 2'b00;
    assign rh = rd_en && rd_sel == 2'(c);

    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      mw |=> (!cnt_held_v[c] && !sts_held_v[c] && !hi_next_v[c])); // R12

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
      (sts_held_v[c] && !rh && !mw) |=> (sts_held_v[c] && $stable(sts_q_v[c*8 +: 8]))); // R6

    AST_STS_READ: assert property (@(posedge clk) disable iff (rst)
      (rh && sts_held_v[c] && !ctl_we) |=> (!sts_held_v[c] && rd_data == $past(sts_q_v[c*8 +: 8]))); // R7

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (cnt_held_v[c] && !rh && !mw) |=> (cnt_held_v[c] && $stable(cnt_q_v[c*CW +: CW]))); // R2
  end
endmodule

bind timer_readback trb_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .cnt_held_v(cnt_held_v), .sts_held_v(sts_held_v), .hi_next_v(hi_next_v),
  .cnt_q_v(cnt_q_v), .sts_q_v(sts_q_v)
);

// File: tb/test_timer_readback.sv
`timescale 1ns/1ps
module test_timer_readback;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;

  logic [15:0] lv [3];
  logic [2:0]  md [3];
  logic [1:0]  ac [3];
  logic        bc [3], ol [3], nl [3];

  logic [3*CW-1:0] live_cnt;
  logic [8:0] ch_mode;
  logic [2:0] ch_bcd, ch_out, ch_null;
  logic [5:0] ch_acc;

  always_comb begin
    live_cnt = {lv[2], lv[1], lv[0]};
    ch_mode  = {md[2], md[1], md[0]};
    ch_acc   = {ac[2], ac[1], ac[0]};
    ch_bcd   = {bc[2], bc[1], bc[0]};
    ch_out   = {ol[2], ol[1], ol[0]};
    ch_null  = {nl[2], nl[1], nl[0]};
  end

  always #2 clk = ~clk;

  timer_readback #(.CW(CW)) i_timer_readback (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .live_cnt(live_cnt), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .ch_acc(ch_acc), .ch_out(ch_out), .ch_null(ch_null),
    .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_cnt [3];
  bit          m_ch [3], m_sh [3], m_hi [3];
  logic [7:0]  m_sts [3];
  logic [7:0]  exp_rd;

  function automatic logic [15:0] fmt(input int c);
    int v;
    if (!bc[c]) return lv[c];
    v = int'(lv[c]);
    return 16'((v % 10) + ((v / 10) % 10) * 16 + ((v / 100) % 10) * 256 + ((v / 1000) % 10) * 4096);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exv);
    total++;
    if (act !== exv) begin
      bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h at %0t", tag, act, exv, $time);
    end
  endtask

  task automatic model(input bit we, input logic [7:0] wd, input bit re, input int sel);
    logic [15:0] src;
    if (re) begin
      src = m_ch[sel] ? m_cnt[sel] : fmt(sel);
      if (m_sh[sel]) begin
        exp_rd = m_sts[sel];
        m_sh[sel] = 0;
      end else if (ac[sel] == 2'b01) begin
        exp_rd = src[7:0]; m_ch[sel] = 0;
      end else if (ac[sel] == 2'b10) begin
        exp_rd = src[15:8]; m_ch[sel] = 0;
      end else if (!m_hi[sel]) begin
        exp_rd = src[7:0]; m_hi[sel] = 1;
      end else begin
        exp_rd = src[15:8]; m_hi[sel] = 0; m_ch[sel] = 0;
      end
    end
    if (we) begin
      int s;
      s = int'(wd[7:6]);
      if (s == 3) begin
        bit found;
        found = 0;
        for (int c = 0; c < 3; c++) begin
          if (wd[c+1]) begin
            if (!wd[5] && !m_ch[c]) begin m_ch[c] = 1; m_cnt[c] = fmt(c); end
            if (!wd[4] && !found && !m_sh[c]) begin
              m_sh[c] = 1;
              m_sts[c] = {ol[c], nl[c], ac[c], md[c], bc[c]};
            end
            found = 1;
          end
        end
      end else if (wd[5:4] == 2'b00) begin
        if (!m_ch[s]) begin m_ch[s] = 1; m_cnt[s] = fmt(s); end
      end else begin
        m_ch[s] = 0; m_sh[s] = 0; m_hi[s] = 0;
      end
    end
  endtask

  // one host operation per cycle; compare after the edge
  task automatic step(input bit we, input logic [7:0] wd, input bit re, input int sel, input string tag);
    ctl_we = we; ctl_data = wd; rd_en = re; rd_sel = 2'(sel);
    model(we, wd, re, sel);
    @(negedge clk);
    ctl_we = 0; rd_en = 0;
    check(tag, rd_data, exp_rd);
  endtask

  task automatic rd(input int sel, input string tag);
    step(0, 8'h00, 1, sel, tag);
  endtask

  task automatic cw(input logic [7:0] wd, input string tag);
    step(1, wd, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: rd_data=%02h expected=end of run", rd_data);
    finish_run();
  end

  initial begin
    lv[0] = 16'h1234; lv[1] = 16'hABCD; lv[2] = 16'h0F0E;
    md[0] = 3'd3; md[1] = 3'd2; md[2] = 3'd0;
    for (int c = 0; c < 3; c++) begin
      ac[c] = 2'b11; bc[c] = 0; ol[c] = 0; nl[c] = 0;
      m_cnt[c] = '0; m_ch[c] = 0; m_sh[c] = 0; m_hi[c] = 0; m_sts[c] = '0;
    end
    ol[0] = 1;
    exp_rd = 8'h00;
    repeat (3) @(negedge clk);
    check("R13 reset", rd_data, 8'h00);
    rst = 0;
    @(negedge clk);
    check("R13 idle", rd_data, 8'h00);

    // R11, R8: live low then high
    rd(0, "R11"); rd(0, "R8"); step(0, 0, 0, 0, "R13 hold");

    // R1, R2: freeze and ignored re-freeze
    cw(8'h40, "R1"); lv[1] = 16'h1111;
    rd(1, "R1");
    lv[1] = 16'h2222; cw(8'h40, "R2");
    rd(1, "R2"); rd(1, "R8 release"); rd(1, "R8");

    // R3: multi-channel freeze
    cw(8'hDE, "R3");
    lv[0] = 16'h5555; lv[1] = 16'h6666; lv[2] = 16'h7777;
    rd(0, "R3"); rd(0, "R3"); rd(1, "R3"); rd(1, "R3"); rd(2, "R3"); rd(2, "R3");

    // R4, R5: status for lowest enabled only
    cw(8'hEA, "R4");
    rd(2, "R4"); rd(2, "R4");
    rd(0, "R5"); rd(0, "R7"); rd(0, "R7");

    // R6: sticky status
    nl[1] = 1; ol[1] = 0;
    cw(8'hE4, "R6"); ol[1] = 1; nl[1] = 0;
    cw(8'hE4, "R6");
    rd(1, "R6"); rd(1, "R7"); rd(1, "R7");

    // R7: status plus count in one command
    cw(8'hC2, "R7"); lv[0] = 16'h9876;
    rd(0, "R7"); rd(0, "R7"); rd(0, "R7"); rd(0, "R11"); rd(0, "R11");

    // R12: mode word clears freeze, status and pointer
    lv[0] = 16'hA1B2;
    cw(8'h00, "R12"); rd(0, "R12"); cw(8'hE2, "R12");
    cw(8'h36, "R12"); lv[0] = 16'hC3D4;
    rd(0, "R12"); rd(0, "R12");

    // R9: single-byte access modes
    ac[2] = 2'b01; cw(8'h90, "R9");
    lv[2] = 16'h4321; cw(8'h80, "R9"); lv[2] = 16'h8765;
    rd(2, "R9"); rd(2, "R9");
    ac[2] = 2'b10; cw(8'hA0, "R9");
    cw(8'h80, "R9"); lv[2] = 16'h1357;
    rd(2, "R9"); rd(2, "R9");

    // R10: BCD conversion, live and frozen
    bc[1] = 1; cw(8'h71, "R10");
    lv[1] = 16'd1234; rd(1, "R10"); rd(1, "R10");
    lv[1] = 16'd9999; cw(8'h40, "R10"); lv[1] = 16'd5;
    rd(1, "R10"); rd(1, "R10"); rd(1, "R10"); rd(1, "R10");
    lv[1] = 16'd12345; rd(1, "R10"); rd(1, "R10");

    step(0, 0, 0, 0, "R13 hold");
    finish_run();
  end
endmodule